// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-master serial peripheral interface controller that a processor programs through 32-bit register reads and writes. Software writes words into a transmit queue and reads received words from a receive queue. A shift engine moves each queued word out on the serial data output while it captures the serial data input. Clock polarity, clock phase and bit order are set in a control register. The serial clock rate is fixed at build time by a divider parameter and cannot be changed by software.

A hold bit in the control register lets software preload a whole burst before any bit moves. Clearing the bit starts draining the queue onto the bus. The slave-select pins come from a select register. They are driven either continuously (manual mode) or only while a word is being shifted. An internal loopback path feeds the serial output back to the serial input, so software can test the datapath without a slave attached. Data is right-aligned in the 32-bit data ports, and the word width is a parameter (8, 16 or 32).

Top module: `spim_top`

## Requirements
- R1: After reset the status register reads 0x05 (both queues empty), the control register reads 0, the select register reads all ones, every select pin is high and the serial clock is low.
- R2: Register offsets are control 0x60, status 0x64, transmit data 0x68 (write pushes), receive data 0x6C (read pops) and select 0x70. Read data appears on the read port one cycle after the read strobe.
- R3: Status bit 3 (transmit full) sets exactly when the transmit queue holds FIFO_DEPTH words. A write while the queue is full is ignored and does not show up in the received stream.
- R4: While control bit 8 (hold) is 1, written words stay queued, the serial clock stays at its idle level and nothing is received. Clearing the bit starts shifting.
- R5: Each shifted word pushes exactly one captured word into the receive queue. Status bit 1 (receive full) and bit 2 (transmit empty) report the queue levels.
- R6: With control bit 0 (loopback) set, the received word equals the transmitted word. With it clear, the received bits come from the serial input pin.
- R7: Control bit 9 selects the bit order: 1 sends the least significant bit first, 0 sends the most significant bit first.
- R8: Control bit 3 sets the idle clock level. Control bit 4 selects the sampling edge: 0 samples on the leading edge, 1 on the trailing edge. Data is stable at the sampling edge in all four combinations, and the clock returns to its idle level after each word.
- R9: While control bit 7 (manual select) is 1, the select pins equal the select register. While it is 0, they equal the select register only during shifting and are all ones otherwise.
- R10: Writing 1 to control bit 5 empties the transmit queue and writing 1 to control bit 6 empties the receive queue. Both bits read back as 0.
- R11: A receive-data read of an empty queue returns 0 and changes nothing.
- R12: No shifting starts unless control bit 1 (enable) and control bit 2 (master) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NUM_SS | Active-low slave selects |

## Verification
Register reads are due one cycle after the strobe. The bench raises the strobe for a single cycle and samples on the falling edge that follows the capturing rising edge. A word occupies 2*WORD_W*CLK_DIV cycles on the wire, plus one cycle to start and one to push the result. The bench therefore waits a margin of several word times before it reads status or received data, and it never samples while a transfer may still be running. The select pins are registered, so the bench checks them a few cycles after the mode or transfer change that moves them. Wire-level order and phase are checked by a bench slave that captures the serial output on the edge implied by polarity and phase.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h60;
  localparam logic [7:0] ADDR_STAT = 8'h64;
  localparam logic [7:0] ADDR_TXD  = 8'h68;
  localparam logic [7:0] ADDR_RXD  = 8'h6C;
  localparam logic [7:0] ADDR_SSR  = 8'h70;

  localparam int CB_LOOP   = 0;
  localparam int CB_EN     = 1;
  localparam int CB_MASTER = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CPHA   = 4;
  localparam int CB_TXRST  = 5;
  localparam int CB_RXRST  = 6;
  localparam int CB_MANSEL = 7;
  localparam int CB_HOLD   = 8;
  localparam int CB_LSB    = 9;
  localparam int CTRL_W    = 10;

  localparam logic [CTRL_W-1:0] CTRL_PULSE_MASK = (CTRL_W'(1) << CB_TXRST) | (CTRL_W'(1) << CB_RXRST);
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  // R3: a push into a full queue leaves it full and the count unchanged
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (full && $stable(cnt)));

  // R11: a pop from an empty queue leaves it empty
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !flush) |=> empty);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W       = 8,
  parameter int CLK_DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         lsb_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_word_o,
  output logic         sclk_o,
  output logic         mosi_o
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);
  localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          busy_q, done_q, sclk_q;
  logic [DW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic [W-1:0]  tx_sr, rx_sr;

  logic is_sample, is_shift;
  assign is_sample = (edge_q[0] == cpha_i);
  assign is_shift  = !is_sample && (edge_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= cpol_i;
        if (start_i) begin
          busy_q <= 1'b1;
          div_q  <= '0;
          edge_q <= '0;
          tx_sr  <= word_i;
        end
      end else if (div_q == DW'(CLK_DIV - 1)) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        if (is_sample) begin
          if (lsb_i) rx_sr <= {miso_i, rx_sr[W-1:1]};
          else       rx_sr <= {rx_sr[W-2:0], miso_i};
        end
        if (is_shift) begin
          if (lsb_i) tx_sr <= {1'b0, tx_sr[W-1:1]};
          else       tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
        if (edge_q == EW'(EDGES - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          edge_q <= edge_q + EW'(1);
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_sr;
  assign sclk_o    = sclk_q;
  assign mosi_o    = lsb_i ? tx_sr[0] : tx_sr[W-1];

  // R8: after an even number of toggles the clock is back at its idle level
  p_sclk_returns_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (sclk_q == cpol_i));

  // R5: a finished word is reported once, with the engine idle
  p_one_done_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_SS     = 4,
  parameter int CLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_n_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_SS-1:0] ssr_q, ss_n_q;
  logic [31:0]       rdata_q;

  logic wr_ctrl, wr_txd, wr_ssr, rd_rxd;
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_txd  = bus_wr && (bus_addr == ADDR_TXD);
  assign wr_ssr  = bus_wr && (bus_addr == ADDR_SSR);
  assign rd_rxd  = bus_rd && (bus_addr == ADDR_RXD);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  logic tx_flush, rx_flush;
  assign tx_flush = wr_ctrl && bus_wdata[CB_TXRST];
  assign rx_flush = wr_ctrl && bus_wdata[CB_RXRST];

  logic [WORD_W-1:0] tx_head, rx_head, sh_rx_word;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic sh_busy, sh_done, sh_start, sh_mosi, sh_sclk, miso_eff;

  assign sh_start = !sh_busy && !tx_empty && !tx_flush &&
                    ctrl_q[CB_EN] && ctrl_q[CB_MASTER] && !ctrl_q[CB_HOLD];
  assign miso_eff = ctrl_q[CB_LOOP] ? sh_mosi : miso_i;

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(wr_txd), .pop(sh_start), .din(bus_wdata[WORD_W-1:0]),
    .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(sh_done), .pop(rd_rxd), .din(sh_rx_word),
    .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spim_shift #(.W(WORD_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start_i(sh_start), .word_i(tx_head),
    .cpol_i(ctrl_q[CB_CPOL]), .cpha_i(ctrl_q[CB_CPHA]), .lsb_i(ctrl_q[CB_LSB]),
    .miso_i(miso_eff), .busy_o(sh_busy), .done_o(sh_done),
    .rx_word_o(sh_rx_word), .sclk_o(sh_sclk), .mosi_o(sh_mosi)
  );

  // control and select registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ssr_q  <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0] & ~CTRL_PULSE_MASK;
      if (wr_ssr)  ssr_q  <= bus_wdata[NUM_SS-1:0];
    end
  end

  // select pins: register value while manual or shifting, else released
  always_ff @(posedge clk) begin
    if (rst) ss_n_q <= '1;
    else if (ctrl_q[CB_MANSEL] || sh_busy) ss_n_q <= ssr_q;
    else ss_n_q <= '1;
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_CTRL: rdata_q <= 32'(ctrl_q);
        ADDR_STAT: rdata_q <= {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
        ADDR_RXD:  rdata_q <= rx_empty ? 32'd0 : 32'(rx_head);
        ADDR_SSR:  rdata_q <= 32'(ssr_q);
        default:   rdata_q <= 32'd0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign sclk_o    = sh_sclk;
  assign mosi_o    = sh_mosi;
  assign ss_n_o    = ss_n_q;

  // R4: the hold bit keeps an idle engine idle
  p_hold_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_HOLD] && !sh_busy) |=> !sh_busy);

  // R12: no start without enable and master
  p_need_enable_r12: assert property (@(posedge clk) disable iff (rst)
    (!(ctrl_q[CB_EN] && ctrl_q[CB_MASTER]) && !sh_busy) |=> !sh_busy);

  // R9: manual select puts the register on the pins
  p_manual_sel_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_MANSEL] && !wr_ssr) |=> (ss_n_o == ssr_q));

  // R11: reading an empty receive queue returns zero
  p_empty_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_rxd && rx_empty) |=> (bus_rdata == 32'd0));

  // R5: a finished word always lands in a queue that had room or was flushed
  p_rx_push_r5: assert property (@(posedge clk) disable iff (rst)
    (sh_done && !rx_full && !rx_flush && !rd_rxd) |=> !rx_empty);
endmodule

// File: tb/spim_top_bench.sv
`timescale 1ns/1ps
module spim_top_bench;
  localparam int W = 8;
  localparam int DEPTH = 16;
  localparam int NSS = 4;
  localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68, A_RXD = 8'h6C, A_SSR = 8'h70;
  localparam logic [31:0] C_LOOP = 32'h1, C_EN = 32'h2, C_MST = 32'h4, C_CPOL = 32'h8,
                          C_CPHA = 32'h10, C_TXR = 32'h20, C_RXR = 32'h40, C_MAN = 32'h80,
                          C_HOLD = 32'h100, C_LSB = 32'h200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sclk, mosi;
  logic miso_drv = 1'b1;
  logic [NSS-1:0] ss_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spim_top #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .NUM_SS(NSS), .CLK_DIV(2)) u_spim_top (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso_drv), .ss_n_o(ss_n)
  );

  // bench slave capturing the serial output on the mode's sampling edge
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [31:0] slv_sr = '0;
  int slv_bits = 0;
  always @(sclk) begin
    if (!rst && (sclk == (cfg_cpol ~^ cfg_cpha))) begin
      slv_sr = {slv_sr[30:0], mosi};
      slv_bits = slv_bits + 1;
    end
  end

  function automatic logic [W-1:0] rev(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  function automatic logic [31:0] stat_val(input logic txf, input logic txe, input logic rxf, input logic rxe);
    return {28'b0, txf, txe, rxf, rxe};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [W-1:0] words [DEPTH];
    logic [W-1:0] w;
    void'($urandom(32'd2024));

    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    bus_read(A_STAT, d); check("R1 status", d, 32'h5);
    bus_read(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    bus_read(A_SSR, d);  check("R1 ssr", d, 32'hF);
    check("R1 ss pins", 32'(ss_n), 32'hF);
    check("R1 sclk", 32'(sclk), 32'h0);

    // R10 reset bits read back as zero; R2 control readback
    bus_write(A_CTRL, C_LOOP | C_EN | C_MST | C_TXR | C_RXR | C_MAN | C_HOLD);
    bus_read(A_CTRL, d); check("R10 ctrl pulse bits", d, C_LOOP | C_EN | C_MST | C_MAN | C_HOLD);

    // R9 manual select drives the register
    bus_write(A_SSR, 32'hE);
    idle(2);
    check("R9 manual select", 32'(ss_n), 32'hE);

    // R3 fill the transmit queue under hold
    for (int i = 0; i < DEPTH; i++) begin
      words[i] = W'($urandom());
      bus_write(A_TXD, 32'(words[i]));
      if (i == DEPTH - 2) begin
        bus_read(A_STAT, d); check("R3 not full one short", 32'(d[3]), 32'h0);
      end
    end
    bus_read(A_STAT, d); check("R3 full at depth", d, stat_val(1, 0, 0, 1));
    bus_write(A_TXD, 32'h5A);   // ignored
    // R4 nothing moves while held
    idle(100);
    check("R4 sclk idle under hold", 32'(sclk), 32'h0);
    bus_read(A_STAT, d); check("R4 nothing received", d, stat_val(1, 0, 0, 1));

    // R4 release; R5/R6 loopback stream
    bus_write(A_CTRL, C_LOOP | C_EN | C_MST | C_MAN);
    idle(DEPTH * 40 + 60);
    bus_read(A_STAT, d); check("R5 levels after burst", d, stat_val(0, 1, 1, 0));
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(A_RXD, d); check("R6 loopback word", d, 32'(words[i]));
    end
    // R11 empty read
    bus_read(A_RXD, d); check("R11 empty read zero", d, 32'h0);
    bus_read(A_STAT, d); check("R3 extra write dropped", d, stat_val(0, 1, 0, 1));

    // R7/R8/R6 all modes and both orders, external input held high
    miso_drv = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int lsb = 0; lsb < 2; lsb++) begin
        cfg_cpol = m[1];
        cfg_cpha = m[0];
        bus_write(A_CTRL, C_EN | C_MST | C_MAN | (m[1] ? C_CPOL : 0) |
                          (m[0] ? C_CPHA : 0) | (lsb != 0 ? C_LSB : 0));
        idle(3);
        slv_bits = 0;
        slv_sr = '0;
        w = W'($urandom());
        bus_write(A_TXD, 32'(w));
        idle(60);
        check("R8 idle clock level", 32'(sclk), 32'(m[1]));
        check("R8 bits sampled", 32'(slv_bits), 32'(W));
        if (lsb != 0) check("R7 lsb first on wire", 32'(slv_sr[W-1:0]), 32'(rev(w)));
        else          check("R7 msb first on wire", 32'(slv_sr[W-1:0]), 32'(w));
        bus_read(A_RXD, d); check("R6 input pin captured", d, 32'hFF);
      end
    end

    // R9 automatic select, loopback on
    cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    bus_write(A_CTRL, C_LOOP | C_EN | C_MST);
    bus_write(A_SSR, 32'hD);
    idle(3);
    check("R9 released when idle", 32'(ss_n), 32'hF);
    w = W'($urandom());
    bus_write(A_TXD, 32'(w));
    idle(10);
    check("R9 driven while shifting", 32'(ss_n), 32'hD);
    idle(50);
    check("R9 released after word", 32'(ss_n), 32'hF);
    bus_read(A_RXD, d); check("R5 one word back", d, 32'(w));

    // R12 enable required
    bus_write(A_CTRL, C_LOOP | C_MST);
    bus_write(A_TXD, 32'h3C);
    idle(60);
    bus_read(A_STAT, d); check("R12 no shift without enable", d, stat_val(0, 0, 0, 1));
    bus_write(A_CTRL, C_LOOP | C_EN | C_MST);
    idle(60);
    bus_read(A_STAT, d); check("R12 shifts once enabled", d, stat_val(0, 1, 0, 0));

    // R10 receive and transmit flush
    bus_write(A_CTRL, C_LOOP | C_EN | C_MST | C_RXR);
    bus_read(A_STAT, d); check("R10 receive flush", d, stat_val(0, 1, 0, 1));
    bus_write(A_CTRL, C_LOOP | C_MST);
    bus_write(A_TXD, 32'h77);
    bus_write(A_CTRL, C_LOOP | C_MST | C_TXR);
    bus_read(A_STAT, d); check("R10 transmit flush", d, stat_val(0, 1, 0, 1));

    finish_run();
  end
endmodule